// File: doc/BRIEF.md
# Multi-bank OUT endpoint packet buffer

This block holds the payloads that a USB host sends to one bulk or interrupt OUT endpoint of a device. A packet-level front end, which has already handled the PHY, CRC, token decode and data toggle, marks the start of each OUT transaction with a one-cycle token pulse. It then streams the payload bytes and ends the packet with a one-cycle end-of-packet marker. The buffer owns between one and three storage banks. It accepts a packet only when the bank that is next in round-robin order is empty. It answers each packet with an ACK or NAK handshake code. A packet that arrives while no bank is free is dropped, and the host has to retry it later.

The local side drains the banks through a byte-wide valid/ready read stream, always from the oldest filled bank. Plain status outputs give the data-ready flag and the byte count of that oldest bank, and a busy level that is high while every bank is occupied. A mode pin selects who frees a drained bank. In automatic mode the buffer frees the bank itself once its last byte is read, and it frees a zero-length bank on its own one cycle after exposing it. In manual mode the local side frees the bank with a one-cycle clear pulse.

Stream rules: `rx_ready` is high while a packet is open and the payload stream is never stalled. A byte sent past the size limit or into a refused packet is counted and then dropped. Bytes and the end marker come in separate cycles, and a token in the same cycle takes precedence. On the read side a byte is consumed only in a cycle where `rd_valid` and `rd_ready` are both high, and `rd_data` holds steady while the reader stalls.

Top module: `out_ep_bankbuf`

## Requirements
- R1: After a token finds the next bank free, the bytes are stored. The cycle after the end marker gives `hs_valid`=1 and `hs_code`=0 (ACK), and if no older bank is pending, `rx_rdy`=1 with `byte_cnt` equal to the payload length.
- R2: If the next bank in order is occupied when the token arrives, the packet is answered with `hs_code`=1 (NAK). Its payload is discarded, and the stored banks keep their counts and contents.
- R3: `busy_irq` is 1 exactly while all NBANK banks hold data.
- R4: With `auto_valid`=1, a bank is freed on the clock edge that consumes its last byte. The next filled bank, if there is one, is presented in the following cycle.
- R5: A zero-length packet on a free bank gets an ACK. It raises `rx_rdy` with `byte_cnt`=0 and writes nothing, and `rd_valid` stays low.
- R6: With `auto_valid`=1, a zero-length bank at the head keeps `rx_rdy` high for exactly one cycle and is then freed without `rx_clr`.
- R7: Banks are filled and drained in round-robin order, so packets are read back in the order they were ACKed.
- R8: A packet of more than MAXPKT bytes takes no bank. The cycle after its end marker gives `ovf_pulse`=1 together with a NAK.
- R9: With `auto_valid`=0, a drained bank stays occupied (`rx_rdy`=1, `byte_cnt` unchanged) until a one-cycle `rx_clr` pulse frees it, including any bytes still unread.
- R10: `hs_valid` is a single-cycle pulse one cycle after the end marker, and `hs_code` encodes 0 = ACK, 1 = NAK.
- R11: `rd_valid` is high only while the head bank has unread bytes. `rd_data` advances only on `rd_valid && rd_ready` and stays stable while `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_valid | input | 1 | 1: the buffer frees drained banks itself; 0: `rx_clr` frees them |
| tok_out | input | 1 | One-cycle pulse marking the start of an OUT packet |
| rx_valid | input | 1 | Payload byte valid |
| rx_ready | output | 1 | High while a packet is open |
| rx_data | input | DW | Payload byte |
| rx_eop | input | 1 | One-cycle end-of-packet marker |
| hs_valid | output | 1 | Handshake result valid (one cycle) |
| hs_code | output | 1 | 0 = ACK, 1 = NAK |
| ovf_pulse | output | 1 | Packet exceeded MAXPKT (with its handshake) |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Reader accepts the byte |
| rd_data | output | DW | Byte from the head bank |
| rx_rdy | output | 1 | Head bank holds a received packet |
| byte_cnt | output | $clog2(MAXPKT+1) | Length of the head bank's packet, 0 when none |
| busy_irq | output | 1 | Every bank occupied |
| rx_clr | input | 1 | Manual-mode release pulse for the head bank |

## Verification
The bench builds the buffer with NBANK=3 and MAXPKT=8. Three banks let it fill the ring, see the busy level, get a NAK on a fourth packet and check that the pointers wrap in order. The small packet limit makes an exact-size packet and a one-byte-over packet cheap to send. Both release modes run on the same instance, including a zero-length packet in each mode and a reader that holds off `rd_ready`.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef enum logic {
    HS_ACK = 1'b0,
    HS_NAK = 1'b1
  } hs_e;
endpackage

// File: rtl/oep_rx_ctrl.sv
module oep_rx_ctrl
  import oep_pkg::*;
#(
  parameter int MAXPKT = 64,
  parameter int DW     = 8,
  parameter int LW     = 7,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          bank_free,
  output logic          rx_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic [LW-1:0] commit_len,
  output logic          hs_valid,
  output hs_e           hs_code,
  output logic          ovf_pulse
);
  logic          open_q, acc_q, ovf_q;
  logic [LW-1:0] len_q;
  logic          byte_ok, eop_ok, at_limit;

  always_comb begin
    at_limit   = (len_q == LW'(MAXPKT));
    byte_ok    = open_q && rx_valid && !rx_eop && !tok_out;
    eop_ok     = open_q && rx_eop && !tok_out;
    rx_ready   = open_q;
    wr_en      = byte_ok && acc_q && !at_limit;
    wr_idx     = len_q[AW-1:0];
    wr_data    = rx_data;
    commit     = eop_ok && acc_q && !ovf_q;
    commit_len = len_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      acc_q     <= 1'b0;
      ovf_q     <= 1'b0;
      len_q     <= '0;
      hs_valid  <= 1'b0;
      hs_code   <= HS_ACK;
      ovf_pulse <= 1'b0;
    end else begin
      hs_valid  <= 1'b0;
      ovf_pulse <= 1'b0;
      if (tok_out) begin
        open_q <= 1'b1;
        acc_q  <= bank_free;
        ovf_q  <= 1'b0;
        len_q  <= '0;
      end else if (eop_ok) begin
        open_q    <= 1'b0;
        hs_valid  <= 1'b1;
        hs_code   <= commit ? HS_ACK : HS_NAK;
        ovf_pulse <= ovf_q;
      end else if (byte_ok) begin
        if (at_limit) ovf_q <= 1'b1;
        else          len_q <= len_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oep_bank_store.sv
module oep_bank_store #(
  parameter int NBANK  = 2,
  parameter int MAXPKT = 64,
  parameter int DW     = 8,
  parameter int LW     = 7,
  parameter int AW     = 6,
  parameter int PW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [LW-1:0] commit_len,
  input  logic          release_head,
  input  logic [AW-1:0] rd_idx,
  output logic          wr_free,
  output logic          head_full,
  output logic [LW-1:0] head_cnt,
  output logic [DW-1:0] head_byte,
  output logic          all_full
);
  logic [NBANK-1:0] full;
  logic [LW-1:0]    cnt      [NBANK];
  logic [DW-1:0]    bank_out [NBANK];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    if (p == PW'(NBANK - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (commit)       wr_ptr <= step_ptr(wr_ptr);
      if (release_head) rd_ptr <= step_ptr(rd_ptr);
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          full_q;
    logic [LW-1:0] cnt_q;
    logic [DW-1:0] mem [MAXPKT];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else if (commit && wr_ptr == PW'(b)) begin
        full_q <= 1'b1;
        cnt_q  <= commit_len;
      end else if (release_head && rd_ptr == PW'(b)) begin
        full_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_ptr == PW'(b)) mem[wr_idx] <= wr_data;
    end

    assign full[b]     = full_q;
    assign cnt[b]      = cnt_q;
    assign bank_out[b] = mem[rd_idx];
  end

  assign wr_free   = !full[wr_ptr];
  assign head_full = full[rd_ptr];
  assign head_cnt  = cnt[rd_ptr];
  assign head_byte = bank_out[rd_ptr];
  assign all_full  = &full;
endmodule

// File: rtl/oep_rd_port.sv
module oep_rd_port #(
  parameter int LW = 7,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_valid,
  input  logic          rx_clr,
  input  logic          head_full,
  input  logic [LW-1:0] head_cnt,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_idx,
  output logic          release_head
);
  logic [LW-1:0] idx_q;
  logic          fire, last;

  always_comb begin
    rd_valid     = head_full && (idx_q < head_cnt);
    fire         = rd_valid && rd_ready;
    last         = fire && (idx_q == head_cnt - 1'b1);
    release_head = head_full &&
                   (auto_valid ? ((head_cnt == '0) || last) : rx_clr);
    rd_idx       = idx_q[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            idx_q <= '0;
    else if (release_head) idx_q <= '0;
    else if (fire)         idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/out_ep_bankbuf.sv
module out_ep_bankbuf
  import oep_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int MAXPKT = 64,
  parameter int DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         auto_valid,
  input  logic                         tok_out,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic [DW-1:0]                rx_data,
  input  logic                         rx_eop,
  output logic                         hs_valid,
  output logic                         hs_code,
  output logic                         ovf_pulse,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [DW-1:0]                rd_data,
  output logic                         rx_rdy,
  output logic [$clog2(MAXPKT+1)-1:0]  byte_cnt,
  output logic                         busy_irq,
  input  logic                         rx_clr
);
  localparam int LW = $clog2(MAXPKT + 1);
  localparam int AW = (MAXPKT > 1) ? $clog2(MAXPKT) : 1;
  localparam int PW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic          wr_en, commit, wr_free, head_full, release_head;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] wr_data;
  logic [LW-1:0] commit_len, head_cnt;
  hs_e           hs_q;

  oep_rx_ctrl #(.MAXPKT(MAXPKT), .DW(DW), .LW(LW), .AW(AW)) u_rx (
    .clk, .rst_n, .tok_out, .rx_valid, .rx_data, .rx_eop,
    .bank_free(wr_free), .rx_ready, .wr_en, .wr_idx, .wr_data,
    .commit, .commit_len, .hs_valid, .hs_code(hs_q), .ovf_pulse
  );

  oep_bank_store #(.NBANK(NBANK), .MAXPKT(MAXPKT), .DW(DW),
                   .LW(LW), .AW(AW), .PW(PW)) u_store (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .commit, .commit_len,
    .release_head, .rd_idx, .wr_free, .head_full, .head_cnt,
    .head_byte(rd_data), .all_full(busy_irq)
  );

  oep_rd_port #(.LW(LW), .AW(AW)) u_rd (
    .clk, .rst_n, .auto_valid, .rx_clr, .head_full, .head_cnt,
    .rd_ready, .rd_valid, .rd_idx, .release_head
  );

  assign hs_code  = hs_q;
  assign rx_rdy   = head_full;
  assign byte_cnt = head_full ? head_cnt : '0;
endmodule

// File: rtl/oep_checker.sv
module oep_checker #(
  parameter int NBANK  = 2,
  parameter int MAXPKT = 64,
  parameter int DW     = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        auto_valid,
  input logic                        hs_valid,
  input logic                        hs_code,
  input logic                        ovf_pulse,
  input logic                        rd_valid,
  input logic                        rd_ready,
  input logic [DW-1:0]               rd_data,
  input logic                        rx_rdy,
  input logic [$clog2(MAXPKT+1)-1:0] byte_cnt,
  input logic                        busy_irq,
  input logic                        rx_clr
);
  AST_ACK_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_code) |-> rx_rdy); // R1
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= MAXPKT); // R1
  AST_BUSY_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_irq |-> rx_rdy); // R3
  AST_ZLP_AUTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_valid && rx_rdy && byte_cnt == '0) |=> !busy_irq); // R6
  AST_OVF_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (hs_valid && hs_code)); // R8
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_valid && rx_rdy && !rx_clr) |=> (rx_rdy && $stable(byte_cnt))); // R9
  AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rx_rdy && byte_cnt != '0)); // R11
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rx_clr) |=> (rd_valid && $stable(rd_data))); // R11
endmodule

bind out_ep_bankbuf oep_checker #(.NBANK(NBANK), .MAXPKT(MAXPKT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_valid(auto_valid), .hs_valid(hs_valid),
  .hs_code(hs_code), .ovf_pulse(ovf_pulse), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rx_rdy(rx_rdy),
  .byte_cnt(byte_cnt), .busy_irq(busy_irq), .rx_clr(rx_clr)
);

// File: tb/tb_out_ep_bankbuf.sv
`timescale 1ns/1ps
module tb_out_ep_bankbuf;
  localparam int NB = 3;
  localparam int MP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_valid = 1'b1, tok_out = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0;
  logic rd_ready = 1'b0, rx_clr = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, hs_valid, hs_code, ovf_pulse, rd_valid, rx_rdy, busy_irq;
  logic [7:0] rd_data;
  logic [$clog2(MP+1)-1:0] byte_cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  out_ep_bankbuf #(.NBANK(NB), .MAXPKT(MP), .DW(8)) dut (
    .clk, .rst_n, .auto_valid, .tok_out, .rx_valid, .rx_ready, .rx_data,
    .rx_eop, .hs_valid, .hs_code, .ovf_pulse, .rd_valid, .rd_ready,
    .rd_data, .rx_rdy, .byte_cnt, .busy_irq, .rx_clr
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Sends a packet; returns the handshake seen one cycle after the marker.
  task automatic send_pkt(input int len, input int base,
                          output int hsv, output int code, output int ovf);
    @(posedge clk); #1 tok_out = 1'b1;
    @(posedge clk); #1 tok_out = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = 8'((base + i) & 255);
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_eop = 1'b1;
    @(posedge clk); #1 rx_eop = 1'b0;
    hsv = hs_valid; code = hs_code; ovf = ovf_pulse;
  endtask

  task automatic read_pkt(input int len, input int base, input string tag);
    for (int i = 0; i < len; i++) begin
      rd_ready = 1'b1; #1;
      chk({tag, " rd_valid"}, rd_valid, 1);
      chk({tag, " rd_data"}, rd_data, (base + i) & 255);
      @(posedge clk); #1;
    end
    rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 reset busy", busy_irq, 0);
    chk("R1 reset rx_rdy", rx_rdy, 0);
    chk("R10 reset hs_valid", hs_valid, 0);
    chk("R11 reset rd_valid", rd_valid, 0);
    chk("R1 reset byte_cnt", byte_cnt, 0);
  endtask

  task automatic t_single();
    int v, c, o;
    send_pkt(3, 8'h10, v, c, o);
    chk("R10 hs_valid", v, 1);
    chk("R1 ack", c, 0);
    chk("R1 rx_rdy", rx_rdy, 1);
    chk("R1 byte_cnt", byte_cnt, 3);
    @(posedge clk); #1 chk("R10 hs one cycle", hs_valid, 0);
    read_pkt(3, 8'h10, "R4 read");
    chk("R4 freed after last byte", rx_rdy, 0);
  endtask

  task automatic t_fill();
    int v, c, o;
    send_pkt(2, 8'h20, v, c, o); chk("R1 ack b0", c, 0);
    send_pkt(5, 8'h30, v, c, o); chk("R1 ack b1", c, 0);
    chk("R3 not busy two banks", busy_irq, 0);
    send_pkt(1, 8'h40, v, c, o); chk("R1 ack b2", c, 0);
    chk("R3 busy all banks", busy_irq, 1);
    send_pkt(4, 8'h50, v, c, o);
    chk("R2 nak when full", c, 1);
    chk("R2 hs_valid", v, 1);
    chk("R2 head count kept", byte_cnt, 2);
    read_pkt(2, 8'h20, "R7 first");
    chk("R3 busy drops", busy_irq, 0);
    chk("R4 next bank count", byte_cnt, 5);
    read_pkt(5, 8'h30, "R7 second");
    read_pkt(1, 8'h40, "R7 third");
    chk("R2 nak payload gone", rx_rdy, 0);
  endtask

  task automatic t_zlp_auto();
    int v, c, o;
    send_pkt(0, 0, v, c, o);
    chk("R5 zlp ack", c, 0);
    chk("R5 zlp rx_rdy", rx_rdy, 1);
    chk("R5 zlp byte_cnt", byte_cnt, 0);
    chk("R5 zlp no data", rd_valid, 0);
    @(posedge clk); #1 chk("R6 zlp auto cleared", rx_rdy, 0);
  endtask

  task automatic t_overflow();
    int v, c, o;
    send_pkt(MP + 1, 8'h60, v, c, o);
    chk("R8 overflow nak", c, 1);
    chk("R8 ovf_pulse", o, 1);
    chk("R8 no bank taken", rx_rdy, 0);
    send_pkt(MP, 8'h70, v, c, o);
    chk("R8 max size ack", c, 0);
    chk("R8 max size ovf", o, 0);
    chk("R8 max size count", byte_cnt, MP);
    read_pkt(MP, 8'h70, "R8 max read");
  endtask

  task automatic t_stall();
    int v, c, o;
    send_pkt(3, 8'hA0, v, c, o);
    rd_ready = 1'b0;
    repeat (2) begin
      @(posedge clk); #1;
      chk("R11 stall valid", rd_valid, 1);
      chk("R11 stall data", rd_data, 8'hA0);
    end
    read_pkt(3, 8'hA0, "R11 resume");
    chk("R11 drained", rd_valid, 0);
  endtask

  task automatic t_manual();
    int v, c, o;
    auto_valid = 1'b0;
    send_pkt(2, 8'hC0, v, c, o);
    read_pkt(2, 8'hC0, "R9 read");
    repeat (2) @(posedge clk); #1;
    chk("R9 held after drain", rx_rdy, 1);
    chk("R9 count kept", byte_cnt, 2);
    chk("R9 no more data", rd_valid, 0);
    rx_clr = 1'b1; @(posedge clk); #1 rx_clr = 1'b0;
    chk("R9 clr frees", rx_rdy, 0);
    send_pkt(0, 0, v, c, o);
    repeat (3) @(posedge clk); #1;
    chk("R6 manual zlp held", rx_rdy, 1);
    rx_clr = 1'b1; @(posedge clk); #1 rx_clr = 1'b0;
    chk("R9 zlp clr", rx_rdy, 0);
    auto_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_single();
    t_fill();
    t_zlp_auto();
    t_overflow();
    t_stall();
    t_manual();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule